// File: doc/BRIEF.md
# Async Receive Character Assembler

This block sits after the start detector and the bit sampler of an asynchronous serial receiver. It turns the sampled bits of one character into the byte that is written to the receive queue. A start pulse arms it. Each later bit strobe carries one sampled line value. The data bits come first, least significant first. A parity bit follows when parity is enabled, and then the stop bit. The start bit never reaches the block, and the stop bit is never stored, so both are removed from the byte.

The character length is set to 5, 6, 7 or 8 bits. For an 8-bit character with parity, the parity bit is checked and then dropped. For a shorter character, the received parity bit is kept in the byte directly above the data. Every position left unused is filled with ones. The byte is delivered together with a parity-error flag and a framing-error flag, and a valid pulse marks it. The block then returns to idle and waits for the next start pulse.

Top module: `rxa_char_asm`

## Requirements
- R1: After reset, `valid_o`, `par_err_o` and `frame_err_o` are 0 and `byte_o` is 8'h00.
- R2: Data bits are received least significant first and land in `byte_o` starting at bit 0. With `cfg_len_i` = 2'b11 (8 bits) and parity off, `byte_o` is exactly the eight data bits.
- R3: With 8-bit characters and parity on, the parity strobe is consumed but the parity bit is absent from `byte_o`, which holds only the eight data bits.
- R4: With `cfg_len_i` = 2'b00/01/10 (5/6/7 bits) and parity off, every `byte_o` bit at or above the character length is 1.
- R5: With a 5-, 6- or 7-bit character and parity on, `byte_o[len]` is the received parity bit and every bit above it is 1.
- R6: With parity on, `cfg_par_odd_i` = 1 selects odd parity and 0 selects even parity, counted over the data bits plus the parity bit. A mismatch sets `par_err_o` together with the byte.
- R7: A stop bit sampled as 0 sets `frame_err_o`, and the byte is still delivered with `valid_o`. A stop bit of 1 leaves `frame_err_o` at 0.
- R8: `valid_o` is high for exactly one clock, starting at the edge that samples the stop bit. Further strobes do nothing until a new start pulse arrives.
- R9: Bit strobes while idle, and start pulses while a character is in progress, have no effect on the assembled byte.
- R10: With parity off, `par_err_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start bit detected; arms the assembler when idle |
| bit_stb_i | input | 1 | One-cycle strobe: `bit_i` holds the next sampled bit |
| bit_i | input | 1 | Sampled serial bit value |
| cfg_len_i | input | 2 | Character length code: 0=5, 1=6, 2=7, 3=8 bits |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| byte_o | output | 8 | Assembled byte, held until the next delivery |
| valid_o | output | 1 | One-cycle pulse when `byte_o` is new |
| par_err_o | output | 1 | Parity mismatch on the delivered byte |
| frame_err_o | output | 1 | Stop bit sampled as 0 on the delivered byte |

## Verification
The bench sends characters of every length, with and without parity. It catches a design that puts the parity bit one position too high or too low, or that fills the unused bits with zeros. It also catches a design that leaves the parity bit in an 8-bit byte. Odd and even parity are each run with a correct and with a flipped parity bit. This exposes an inverted sense or a check that also fires when parity is disabled. A character with a low stop bit must still arrive, and carry the framing flag. Stray strobes while idle, and a start pulse in the middle of a character, would shift or restart the bit index in a faulty design. In that case a byte would arrive out of turn, or a wrong byte would arrive.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  localparam int unsigned RXA_BYTE_W  = 8;
  localparam int unsigned RXA_MIN_LEN = 5;
  localparam int unsigned RXA_CODE_W  = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_PAR, ST_STOP} rxa_state_e;

  // number of data bits selected by the length code
  function automatic int unsigned char_bits(input logic [RXA_CODE_W-1:0] code);
    return RXA_MIN_LEN + int'(code);
  endfunction

  // data in the low bits, parity just above when there is room, ones elsewhere
  function automatic logic [RXA_BYTE_W-1:0] pack_byte(
    input logic [RXA_BYTE_W-1:0] data,
    input logic [RXA_CODE_W-1:0] code,
    input logic                  par_en,
    input logic                  par_bit
  );
    logic [RXA_BYTE_W-1:0] b;
    int unsigned n;
    n = char_bits(code);
    for (int i = 0; i < int'(RXA_BYTE_W); i++) begin
      if (i < int'(n))                b[i] = data[i];
      else if (i == int'(n) && par_en) b[i] = par_bit;
      else                            b[i] = 1'b1;
    end
    return b;
  endfunction

  // high when the received parity bit does not match the selected sense
  function automatic logic parity_bad(
    input logic [RXA_BYTE_W-1:0] data,
    input logic [RXA_CODE_W-1:0] code,
    input logic                  par_en,
    input logic                  odd,
    input logic                  par_bit
  );
    logic ones;
    int unsigned n;
    n    = char_bits(code);
    ones = par_bit;
    for (int i = 0; i < int'(RXA_BYTE_W); i++)
      if (i < int'(n)) ones = ones ^ data[i];
    return par_en && (ones != odd);
  endfunction
endpackage

// File: rtl/rxa_seq.sv
module rxa_seq
  import rxa_pkg::*;
#(
  parameter int unsigned BYTE_W = RXA_BYTE_W,
  parameter int unsigned CODE_W = RXA_CODE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       bit_stb_i,
  input  logic [CODE_W-1:0]          len_i,
  input  logic                       par_en_i,
  output logic                       start_acc_o,
  output logic                       cap_data_o,
  output logic                       cap_par_o,
  output logic                       cap_stop_o,
  output logic [$clog2(BYTE_W)-1:0]  idx_o
);
  localparam int unsigned IDX_W = $clog2(BYTE_W);

  rxa_state_e       st_q, st_d;
  logic [IDX_W-1:0] cnt_q;
  logic [IDX_W-1:0] last_idx;
  logic             data_done;

  always_comb begin
    last_idx    = IDX_W'(char_bits(len_i) - 1);
    start_acc_o = (st_q == ST_IDLE) && start_i;
    cap_data_o  = (st_q == ST_DATA) && bit_stb_i;
    cap_par_o   = (st_q == ST_PAR)  && bit_stb_i;
    cap_stop_o  = (st_q == ST_STOP) && bit_stb_i;
    data_done   = cap_data_o && (cnt_q == last_idx);
    idx_o       = cnt_q;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_acc_o) st_d = ST_DATA;
      ST_DATA: if (data_done)   st_d = par_en_i ? ST_PAR : ST_STOP;
      ST_PAR:  if (cap_par_o)   st_d = ST_STOP;
      ST_STOP: if (cap_stop_o)  st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (start_acc_o)     cnt_q <= '0;
      else if (cap_data_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  // the index never runs past the configured last data bit
  p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA) |-> (cnt_q <= last_idx));
  // after the stop sample the sequencer is idle again
  p_idle_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stop_o |=> (st_q == ST_IDLE));
  // a start pulse during a character does not send the sequencer back to idle
  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && st_q != ST_STOP && start_i) |=> (st_q != ST_IDLE));
endmodule

// File: rtl/rxa_shift.sv
module rxa_shift
  import rxa_pkg::*;
#(
  parameter int unsigned BYTE_W = RXA_BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear_i,
  input  logic                      cap_data_i,
  input  logic                      cap_par_i,
  input  logic [$clog2(BYTE_W)-1:0] idx_i,
  input  logic                      bit_i,
  output logic [BYTE_W-1:0]         data_o,
  output logic                      par_o
);
  logic [BYTE_W-1:0] data_q;
  logic              par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      par_q  <= 1'b0;
    end else if (clear_i) begin
      data_q <= '0;
      par_q  <= 1'b0;
    end else begin
      if (cap_data_i) data_q[idx_i] <= bit_i;
      if (cap_par_i)  par_q         <= bit_i;
    end
  end

  assign data_o = data_q;
  assign par_o  = par_q;

  // a data capture writes the sampled value at the current index
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_data_i && !clear_i) |=> (data_q[$past(idx_i)] == $past(bit_i)));
endmodule

// File: rtl/rxa_format.sv
module rxa_format
  import rxa_pkg::*;
#(
  parameter int unsigned BYTE_W = RXA_BYTE_W,
  parameter int unsigned CODE_W = RXA_CODE_W
) (
  input  logic [BYTE_W-1:0] data_i,
  input  logic              par_i,
  input  logic [CODE_W-1:0] len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              par_err_o
);
  always_comb begin
    byte_o    = pack_byte(data_i, len_i, par_en_i, par_i);
    par_err_o = parity_bad(data_i, len_i, par_en_i, par_odd_i, par_i);
  end
endmodule

// File: rtl/rxa_char_asm.sv
module rxa_char_asm
  import rxa_pkg::*;
#(
  parameter int unsigned BYTE_W = RXA_BYTE_W,
  parameter int unsigned CODE_W = RXA_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              bit_stb_i,
  input  logic              bit_i,
  input  logic [CODE_W-1:0] cfg_len_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frame_err_o
);
  localparam int unsigned IDX_W = $clog2(BYTE_W);

  logic              start_acc, cap_data, cap_par, cap_stop;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] raw_data;
  logic              raw_par;
  logic [BYTE_W-1:0] fmt_byte;
  logic              fmt_par_err;

  rxa_seq #(.BYTE_W(BYTE_W), .CODE_W(CODE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_stb_i(bit_stb_i),
    .len_i(cfg_len_i), .par_en_i(cfg_par_en_i),
    .start_acc_o(start_acc), .cap_data_o(cap_data), .cap_par_o(cap_par),
    .cap_stop_o(cap_stop), .idx_o(idx)
  );

  rxa_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear_i(start_acc), .cap_data_i(cap_data),
    .cap_par_i(cap_par), .idx_i(idx), .bit_i(bit_i),
    .data_o(raw_data), .par_o(raw_par)
  );

  rxa_format #(.BYTE_W(BYTE_W), .CODE_W(CODE_W)) u_format (
    .data_i(raw_data), .par_i(raw_par), .len_i(cfg_len_i),
    .par_en_i(cfg_par_en_i), .par_odd_i(cfg_par_odd_i),
    .byte_o(fmt_byte), .par_err_o(fmt_par_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_o      <= '0;
      valid_o     <= 1'b0;
      par_err_o   <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o <= cap_stop;
      if (cap_stop) begin
        byte_o      <= fmt_byte;
        par_err_o   <= fmt_par_err;
        frame_err_o <= !bit_i;
      end
    end
  end

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_frame_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_stop && !bit_i) |=> (valid_o && frame_err_o));
  // configuration is held steady across a character
  p_no_par_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !cfg_par_en_i) |-> !par_err_o);
  p_fill_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cfg_len_i != 2'b11 && !cfg_par_en_i) |-> byte_o[BYTE_W-1]);
endmodule

// File: tb/rxa_char_asm_tb_top.sv
`timescale 1ns/1ps
module rxa_char_asm_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, bit_stb_i = 1'b0, bit_i = 1'b1;
  logic [1:0] cfg_len_i = 2'b11;
  logic       cfg_par_en_i = 1'b0, cfg_par_odd_i = 1'b0;
  logic [7:0] byte_o;
  logic       valid_o, par_err_o, frame_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rxa_char_asm dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_stb_i(bit_stb_i),
    .bit_i(bit_i), .cfg_len_i(cfg_len_i), .cfg_par_en_i(cfg_par_en_i),
    .cfg_par_odd_i(cfg_par_odd_i), .byte_o(byte_o), .valid_o(valid_o),
    .par_err_o(par_err_o), .frame_err_o(frame_err_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic strobe(input logic b, input logic st);
    @(negedge clk);
    bit_i = b; bit_stb_i = 1'b1; start_i = st;
    @(negedge clk);
    bit_stb_i = 1'b0; start_i = 1'b0;
    @(negedge clk);
  endtask

  // one full character; bench builds its own expected byte and flags
  task automatic send_char(input string req, input logic [7:0] d,
                           input logic [1:0] lc, input logic pe, input logic po,
                           input logic flip, input logic stop, input logic mid_start);
    int n;
    logic ones, pbit;
    logic [7:0] exp;
    n = 5 + int'(lc);
    ones = 1'b0;
    for (int i = 0; i < n; i++) ones = ones ^ d[i];
    pbit = ones ^ po ^ flip;
    for (int i = 0; i < 8; i++)
      exp[i] = (i < n) ? d[i] : ((i == n && pe) ? pbit : 1'b1);
    @(negedge clk);
    cfg_len_i = lc; cfg_par_en_i = pe; cfg_par_odd_i = po;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < n; i++) strobe(d[i], mid_start && i == 2);
    if (pe) strobe(pbit, 1'b0);
    @(negedge clk);
    bit_i = stop; bit_stb_i = 1'b1;
    @(posedge clk); #1;
    chk(req, "valid", {7'd0, valid_o}, 8'd1);
    chk(req, "byte", byte_o, exp);
    chk(req, "par_err", {7'd0, par_err_o}, {7'd0, pe & flip});
    chk(req, "frame_err", {7'd0, frame_err_o}, {7'd0, ~stop});
    @(negedge clk);
    bit_stb_i = 1'b0; bit_i = 1'b1;
    @(posedge clk); #1;
    chk("R8", "valid one cycle", {7'd0, valid_o}, 8'd0);
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "valid", {7'd0, valid_o}, 8'd0);
    chk("R1", "byte", byte_o, 8'h00);
    chk("R1", "par_err", {7'd0, par_err_o}, 8'd0);
    chk("R1", "frame_err", {7'd0, frame_err_o}, 8'd0);
  endtask

  task automatic t_idle_strobes;
    int seen;
    seen = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); bit_i = k[0]; bit_stb_i = 1'b1;
      @(posedge clk); #1; if (valid_o) seen++;
      @(negedge clk); bit_stb_i = 1'b0;
    end
    chk("R8", "no valid without start", seen[7:0], 8'd0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    send_char("R2", 8'hA5, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    send_char("R2", 8'h3C, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    send_char("R3", 8'h5A, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    send_char("R3", 8'h81, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    send_char("R4", 8'h15, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    send_char("R4", 8'h2A, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    send_char("R4", 8'h55, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    send_char("R5", 8'h0B, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    send_char("R5", 8'h21, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    send_char("R5", 8'h6E, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    send_char("R6", 8'h33, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    send_char("R6", 8'hC7, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    send_char("R6", 8'h1F, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    send_char("R10", 8'hF0, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    send_char("R7", 8'h96, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send_char("R7", 8'h09, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    t_idle_strobes();
    send_char("R9", 8'h4D, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    send_char("R9", 8'hB2, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule